// File: doc/BRIEF.md
# Stepped Voltage Reference Sequencer

This block turns a 5-bit voltage-identification code into the digital setpoint of a core-voltage reference DAC. A new code is never applied at once. It passes a two-flop synchroniser and a change detector, then must hold steady through a short confirmation wait. After that, the live setpoint walks toward the requested value one 25 mV step at a time, with a fixed number of ticks between steps. This keeps the in-rush current and the output swing small while the supply tracks the new request.

The setpoint is an index in which value 0 stands for 1.850 V and value 30 stands for 1.100 V. The index therefore equals the input code, and each unit of index is 25 mV lower. Code 31 is reserved: it switches the reference off and leaves the index where it was.

A new request can arrive while a ramp is still running. If the setpoint can reach it by moving in the same direction, the ramp carries on without a break. If reaching it needs a reversal, stepping stops and a fresh confirmation wait starts. The choice between these two cases is made against the present intermediate setpoint, not against the old target.

A sequencer supplies two inputs. The `tick` enable paces the engine. The `load` pulse takes the synchronised code straight into the setpoint, which is used once the soft-start ramp has finished.

Top module: `vid_ref_stepper`

## Requirements
- R1: Input code 31 sets `ref_off` and leaves `ref_idx` unchanged. Any other code c in 0..30 clears `ref_off` and makes c the final `ref_idx`. Index c stands for 1.850 V − c × 25 mV.
- R2: A change on `vid` reaches the engine through two synchronising flops. With `tick` high, `busy` is still low two clock edges after the change and is high on the third edge.
- R3: A code that differs from the accepted one for a single clock cycle and then returns leaves `ref_idx` unchanged, and `busy` ends low.
- R4: After detection, the code must stay stable for WAIT_TICKS ticks before stepping starts. If the code changes during that wait, the wait restarts.
- R5: `ref_idx` moves by exactly one per step, one step every STEP_TICKS ticks. With the defaults and `tick` high, a move of n steps (n ≥ 0) completes on edge 5 + 2n after the input change.
- R6: A mid-ramp request that lies further along the current direction of travel is taken with no pause. The ramp simply runs on to the new value.
- R7: A mid-ramp request that needs a reversal halts stepping at once and starts a fresh WAIT_TICKS wait. Stepping then resumes in the new direction.
- R8: The direction test for a mid-ramp request compares it with the current `ref_idx`, not with the previous target. A request between the setpoint and the old target therefore causes no pause.
- R9: `busy` is high from the first detection of a change until `ref_idx` equals the accepted target, or until an off code or a matching code is accepted.
- R10: During a ramp, `ramp_up` is 1 when the voltage is rising (index falling) and 0 when it is falling.
- R11: A `load` pulse copies the synchronised code into `ref_idx` (or sets `ref_off` for code 31) in one edge and leaves `busy` low.
- R12: While `tick` is low, the setpoint and the engine state hold. The ramp resumes where it stopped once `tick` returns.
- R13: After reset, `ref_idx` is RST_IDX (30 by default), `ref_off` is 1 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Engine advance enable |
| load | input | 1 | Take the synchronised code directly as the setpoint |
| vid | input | VID_W | Requested voltage code, asynchronous |
| ref_idx | output | VID_W | Current setpoint index (0 = highest voltage) |
| ref_off | output | 1 | Reference switched off |
| busy | output | 1 | Change pending or ramp in progress |
| ramp_up | output | 1 | Ramp direction, 1 = voltage rising |

## Verification
The bench builds the block with its defaults: a 5-bit code, a two-tick confirmation wait and a two-tick step interval. With these values every move has a closed-form completion edge of 5 + 2n, so each table entry is checked on the exact edge where it must finish and on the edge before it. The 5-bit code also puts both ends of the index range (0 and 30) and the off code within a short run. The directed cases then use those same fixed intervals to tell a halted ramp from a continuing one. They also cover a retarget to an intermediate point and a retarget beyond the old target.

// File: rtl/vid_ref_stepper.sv
module vid_ref_stepper #(
  parameter int VID_W      = 5,
  parameter int WAIT_TICKS = 2,
  parameter int STEP_TICKS = 2,
  parameter int RST_IDX    = (1 << VID_W) - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [VID_W-1:0] vid,
  output logic [VID_W-1:0] ref_idx,
  output logic             ref_off,
  output logic             busy,
  output logic             ramp_up
);

  localparam logic [VID_W-1:0] OFF_CODE = {VID_W{1'b1}};
  localparam int CNT_MAX = (WAIT_TICKS > STEP_TICKS) ? WAIT_TICKS : STEP_TICKS;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_TICKS - 1);
  localparam logic [CW-1:0] STEP_LAST = CW'(STEP_TICKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RAMP} st_t;

  logic [VID_W-1:0] s1, s2;
  st_t              st, st_n;
  logic [CW-1:0]    cnt, cnt_n;
  logic [VID_W-1:0] pend, pend_n, acc, acc_n, idx, idx_n;
  logic             off, off_n, up, up_n, halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= OFF_CODE;
      s2 <= OFF_CODE;
    end else begin
      s1 <= vid;
      s2 <= s1;
    end
  end

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    pend_n = pend;
    acc_n  = acc;
    idx_n  = idx;
    off_n  = off;
    up_n   = up;
    halt   = 1'b0;
    if (load) begin
      st_n   = S_IDLE;
      cnt_n  = '0;
      acc_n  = s2;
      pend_n = s2;
      if (s2 == OFF_CODE) off_n = 1'b1;
      else begin
        off_n = 1'b0;
        idx_n = s2;
      end
    end else if (tick) begin
      case (st)
        S_IDLE: if (s2 != acc) begin
          st_n   = S_WAIT;
          pend_n = s2;
          cnt_n  = '0;
        end
        S_WAIT: begin
          if (s2 != pend) begin
            pend_n = s2;
            cnt_n  = '0;
          end else if (cnt == WAIT_LAST) begin
            acc_n = pend;
            cnt_n = '0;
            if (pend == OFF_CODE) begin
              off_n = 1'b1;
              st_n  = S_IDLE;
            end else begin
              off_n = 1'b0;
              if (pend == idx) st_n = S_IDLE;
              else begin
                st_n = S_RAMP;
                up_n = pend < idx;
              end
            end
          end else cnt_n = cnt + 1'b1;
        end
        S_RAMP: begin
          if (s2 != acc) begin
            if (s2 == OFF_CODE || (s2 != idx && ((s2 < idx) != up))) begin
              halt   = 1'b1;
              st_n   = S_WAIT;
              pend_n = s2;
              cnt_n  = '0;
            end else acc_n = s2;
          end
          if (!halt) begin
            if (acc_n == idx) st_n = S_IDLE;
            else if (cnt == STEP_LAST) begin
              cnt_n = '0;
              idx_n = up ? idx - 1'b1 : idx + 1'b1;
              if (idx_n == acc_n) st_n = S_IDLE;
            end else cnt_n = cnt + 1'b1;
          end
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      pend <= OFF_CODE;
      acc  <= OFF_CODE;
      idx  <= VID_W'(RST_IDX);
      off  <= 1'b1;
      up   <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      pend <= pend_n;
      acc  <= acc_n;
      idx  <= idx_n;
      off  <= off_n;
      up   <= up_n;
    end
  end

  assign ref_idx = idx;
  assign ref_off = off;
  assign busy    = (st != S_IDLE);
  assign ramp_up = up;

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(ref_idx) || ref_idx == $past(ref_idx) + 1'b1 || ref_idx == $past(ref_idx) - 1'b1));

  // R7
  step_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAMP && !load) |=> ($stable(ref_idx) ||
      ($past(ramp_up) ? ref_idx == $past(ref_idx) - 1'b1 : ref_idx == $past(ref_idx) + 1'b1)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> $stable(ref_idx));

  // R12
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> ($stable(ref_idx) && $stable(busy) && $stable(ref_off)));

  // R1
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_off && !load) |=> $stable(ref_idx));

endmodule

// File: tb/test_vid_ref_stepper.sv
module test_vid_ref_stepper;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [4:0] CODES [NV] = '{5'd30, 5'd28, 5'd0, 5'd31, 5'd3, 5'd7, 5'd22, 5'd21};

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, load = 1'b0;
  logic [4:0] vid = 5'd31;
  logic [4:0] ref_idx;
  logic ref_off, busy, ramp_up;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_ref_stepper i_vid_ref_stepper (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .vid(vid),
    .ref_idx(ref_idx), .ref_off(ref_off), .busy(busy), .ramp_up(ramp_up));

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [4:0] c);
    vid = c;
    adv(3);
    load = 1'b1;
    adv(1);
    load = 1'b0;
    chk("R11 load idx", ref_idx, c);
    chk("R11 load busy", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int prev;
    adv(3);
    rst_n = 1'b1;
    adv(1);
    chk("R13 reset idx", ref_idx, 30);
    chk("R13 reset off", ref_off, 1);
    chk("R13 reset busy", busy, 0);

    prev = 30;
    for (int k = 0; k < NV; k++) begin
      int c, n, e, ex;
      c  = CODES[k];
      ex = (c == 31) ? prev : c;
      n  = (c == 31) ? 0 : ((c > prev) ? c - prev : prev - c);
      e  = 5 + 2 * n;
      vid = CODES[k];
      adv(2);
      chk("R2 busy not yet", busy, 0);
      adv(1);
      chk("R2 busy rises", busy, 1);
      adv(e - 4);
      chk("R9 busy before end", busy, 1);
      if (n > 0) begin
        chk("R5 not finished early", (ref_idx == ex), 0);
        chk("R10 direction", ramp_up, (c < prev));
      end
      adv(1);
      chk("R1 final idx", ref_idx, ex);
      chk("R1 off flag", ref_off, (c == 31));
      chk("R5 done on edge", busy, 0);
      prev = ex;
    end

    // R3 one-cycle glitch
    do_load(5'd10);
    vid = 5'd15;
    adv(1);
    vid = 5'd10;
    adv(12);
    chk("R3 glitch idx", ref_idx, 10);
    chk("R3 glitch busy", busy, 0);

    // R8 / R6 retarget between setpoint (14) and old target (20): no pause
    do_load(5'd10);
    vid = 5'd20;
    adv(12);
    vid = 5'd17;
    adv(6);
    chk("R8 running idx", ref_idx, 16);
    chk("R8 still busy", busy, 1);
    adv(1);
    chk("R8 final idx", ref_idx, 17);
    chk("R8 done", busy, 0);

    // R6 retarget beyond old target
    do_load(5'd10);
    vid = 5'd20;
    adv(12);
    vid = 5'd25;
    adv(22);
    chk("R6 idx before end", ref_idx, 24);
    adv(1);
    chk("R6 final idx", ref_idx, 25);
    chk("R6 done", busy, 0);

    // R7 reversal: halt at 14, wait, then climb back
    do_load(5'd10);
    vid = 5'd20;
    adv(12);
    vid = 5'd12;
    adv(3);
    chk("R7 halted idx", ref_idx, 14);
    adv(2);
    chk("R7 still halted", ref_idx, 14);
    chk("R4 wait busy", busy, 1);
    adv(2);
    chk("R7 first back step", ref_idx, 13);
    chk("R10 direction up", ramp_up, 1);
    adv(2);
    chk("R7 final idx", ref_idx, 12);
    chk("R7 done", busy, 0);

    // R12 tick gating
    do_load(5'd10);
    vid = 5'd14;
    adv(8);
    chk("R12 pre-gate idx", ref_idx, 11);
    tick = 1'b0;
    adv(6);
    chk("R12 gated idx", ref_idx, 11);
    chk("R12 gated busy", busy, 1);
    tick = 1'b1;
    adv(5);
    chk("R12 resumed idx", ref_idx, 14);
    chk("R12 resumed done", busy, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule